// File: doc/BRIEF.md
# Image Sensor Row Sequencer

This block drives the line-level control pins of a directly addressed 1024-row image sensor that runs an electronic rolling shutter. Each line has two halves. In the first half it places the row to be read on the address bus, latches it with an active-low strobe, waits for the column bus to settle, and then runs the double-sampling pattern. That pattern is a sample pulse, a reset of the same row, and a second sample pulse. In the second half it latches a different row and resets it. That row lies a programmed number of rows ahead of the read row, which sets the integration time.

All intervals are counts of the system clock, taken from configuration inputs, so one netlist can serve any pixel rate. The read rows start at a window start row and advance by a subsampling step until they pass the window end row, and then a new frame begins. A calibration pulse is issued on the first line of every frame. While the shutter reset and the rest of the line go on, a window signal tells the column sequencer that it may read out the sampled row.

Top module: `img_row_seq`

## Requirements
- R1: The address bus is bit-reversed. Output bit k carries bit (9-k) of the selected row, so bit 0 is the row MSB and bit 9 its LSB. The bus is zero while the block is idle.
- R2: Each line begins with the read row on the bus for 2 cycles. Then the load strobe is low for 4 cycles, and the row stays on the bus for 2 more cycles with the strobe high.
- R3: After that the bus settles for `t_settle` cycles, and then the sample pulse is high for `t_pulse` cycles. Every timing count of zero acts as one.
- R4: After the sample pulse there is a gap of `t_gap` cycles. Then the normal reset is high for `t_rst_w` cycles, followed by `t_rdly` cycles, and then the second sample pulse is high for `t_pulse` cycles. At most one of the two sample pulses, the two resets and the active-low strobe is active in any cycle.
- R5: The shutter half then puts the reset row on the bus for 2 cycles, drives the strobe low for 4 cycles, waits `t_pre` cycles, and resets for `t_rst_w` cycles. It holds the address for `t_post` cycles and then `t_line` cycles more before the next line starts.
- R6: The reset row is the read row plus `int_rows`. If that sum exceeds `win_end`, the window height (`win_end - win_start + 1`) is subtracted once. If the row is still beyond `win_end`, the shutter pulse is dropped, but the line keeps its timing.
- R7: When `ds_en` is 1 the shutter pulse appears on `row_rst_ds`, otherwise on `row_rst`. The read-row reset always uses `row_rst`, and `row_rst_ds` is never high while `ds_en` is 0.
- R8: The read rows run `win_start`, `win_start+step`, and so on, as long as they stay at or below `win_end`. This holds even when the sum passes 1023. The next line after that returns to `win_start` and starts a new frame.
- R9: On the first line of each frame, `cal_pulse` rises `t_cal_dly` cycles after the sample pulse rises and stays high for `t_cal_w` cycles. It stays low on every other line.
- R10: `readout_window` is high from the cycle after the second sample pulse falls until the last cycle of the line.
- R11: While idle, a high `run` starts the first line in the next cycle at `win_start`. A low `run` at the end of a line returns the block to idle.
- R12: During reset and while idle, the strobe is high and every pulse and the window are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keep generating lines |
| ds_en | input | 1 | Route the shutter reset to the dual-slope pin |
| win_start | input | 10 | First row of the window |
| win_end | input | 10 | Last row of the window |
| row_step | input | 10 | Subsampling step between read rows (at least 1) |
| int_rows | input | 11 | Rows between the read row and the reset row, 1 to 1024 |
| t_settle | input | 12 | Cycles from load to sample pulse |
| t_pulse | input | 12 | Width of each sample pulse |
| t_gap | input | 12 | Cycles from the first sample fall to the reset rise |
| t_rst_w | input | 12 | Reset pulse width |
| t_rdly | input | 12 | Cycles from the reset fall to the second sample rise |
| t_pre | input | 12 | Cycles from the shutter load to the reset rise |
| t_post | input | 12 | Address hold after the shutter reset |
| t_line | input | 12 | Remaining readout cycles at the end of the line |
| t_cal_dly | input | 12 | Cycles from the sample rise to the calibration rise |
| t_cal_w | input | 12 | Calibration pulse width |
| row_addr_pins | output | 10 | Bit-reversed row address |
| row_load_n | output | 1 | Active-low address load strobe |
| s_pulse | output | 1 | First column sample pulse |
| r_pulse | output | 1 | Second column sample pulse |
| row_rst | output | 1 | Normal row reset |
| row_rst_ds | output | 1 | Dual-slope row reset |
| cal_pulse | output | 1 | Once-per-frame calibration pulse |
| readout_window | output | 1 | Column readout may run |

## Verification
Every output is decoded from a registered state, so a change of phase shows on the pins one clock edge after the counter of the previous phase expires. `run` takes effect at the next edge, and the calibration pulse runs on its own counter that starts on the edge at which the sample pulse rises. The bench expands each scenario into a queue with one expected pin word per cycle, counted from the first edge that sees `run` high. It pops one entry at every clock, 1 ns after the edge, and compares every field. This checks each pulse position to the exact cycle, and any cycle outside a line is checked against the idle values.

// File: rtl/img_row_seq_pkg.sv
package img_row_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_SU, ST_RD_LD, ST_RD_HD, ST_SETTLE, ST_S, ST_GAP, ST_RRST,
    ST_RDLY, ST_R, ST_SH_SU, ST_SH_LD, ST_SH_PRE, ST_SH_RST, ST_SH_POST, ST_WIN
  } seq_state_e;

  typedef enum logic [1:0] {CAL_OFF, CAL_WAIT, CAL_ON} cal_phase_e;
endpackage

// File: rtl/img_row_seq_addr.sv
module img_row_seq_addr #(
  parameter int ROW_W = 10,
  parameter int INT_W = ROW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             adv,
  input  logic [ROW_W-1:0] win_start,
  input  logic [ROW_W-1:0] win_end,
  input  logic [ROW_W-1:0] row_step,
  input  logic [INT_W-1:0] int_rows,
  output logic [ROW_W-1:0] rd_row,
  output logic             first_line,
  output logic [ROW_W-1:0] sh_row,
  output logic             sh_valid
);
  localparam int SW = ROW_W + 2;

  logic [ROW_W-1:0] rd_row_d;
  logic             first_d;
  logic [ROW_W:0]   nxt_row;
  logic [SW-1:0]    sum, height, alt;

  always_comb begin
    nxt_row  = {1'b0, rd_row} + {1'b0, row_step};
    rd_row_d = rd_row;
    first_d  = first_line;
    if (go) begin
      rd_row_d = win_start;
      first_d  = 1'b1;
    end else if (adv) begin
      if (nxt_row > {1'b0, win_end}) begin
        rd_row_d = win_start;
        first_d  = 1'b1;
      end else begin
        rd_row_d = nxt_row[ROW_W-1:0];
        first_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_row     <= '0;
      first_line <= 1'b0;
    end else if (go || adv) begin
      rd_row     <= rd_row_d;
      first_line <= first_d;
    end
  end

  always_comb begin
    sum    = SW'(rd_row) + SW'(int_rows);
    height = SW'(win_end) - SW'(win_start) + SW'(1);
    alt    = sum;
    if (sum > SW'(win_end)) alt = sum - height;
    sh_valid = (alt <= SW'(win_end));
    sh_row   = alt[ROW_W-1:0];
  end
endmodule

// File: rtl/img_row_seq_fsm.sv
module img_row_seq_fsm
  import img_row_seq_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int ADDR_SU = 2,
  parameter int LD_W    = 4,
  parameter int ADDR_HD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] t_settle,
  input  logic [CNT_W-1:0] t_pulse,
  input  logic [CNT_W-1:0] t_gap,
  input  logic [CNT_W-1:0] t_rst_w,
  input  logic [CNT_W-1:0] t_rdly,
  input  logic [CNT_W-1:0] t_pre,
  input  logic [CNT_W-1:0] t_post,
  input  logic [CNT_W-1:0] t_line,
  output seq_state_e       state_q,
  output logic             go,
  output logic             adv,
  output logic             s_start
);
  seq_state_e       state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, dur;

  function automatic logic [CNT_W-1:0] ld_val(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  always_comb begin
    case (state_d)
      ST_RD_SU, ST_SH_SU: dur = CNT_W'(ADDR_SU);
      ST_RD_LD, ST_SH_LD: dur = CNT_W'(LD_W);
      ST_RD_HD:           dur = CNT_W'(ADDR_HD);
      ST_SETTLE:          dur = t_settle;
      ST_S, ST_R:         dur = t_pulse;
      ST_GAP:             dur = t_gap;
      ST_RRST, ST_SH_RST: dur = t_rst_w;
      ST_RDLY:            dur = t_rdly;
      ST_SH_PRE:          dur = t_pre;
      ST_SH_POST:         dur = t_post;
      ST_WIN:             dur = t_line;
      default:            dur = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    go      = 1'b0;
    adv     = 1'b0;
    if (state_q == ST_IDLE) begin
      if (run) begin
        state_d = ST_RD_SU;
        go      = 1'b1;
      end
    end else if (cnt_q == '0) begin
      case (state_q)
        ST_RD_SU:   state_d = ST_RD_LD;
        ST_RD_LD:   state_d = ST_RD_HD;
        ST_RD_HD:   state_d = ST_SETTLE;
        ST_SETTLE:  state_d = ST_S;
        ST_S:       state_d = ST_GAP;
        ST_GAP:     state_d = ST_RRST;
        ST_RRST:    state_d = ST_RDLY;
        ST_RDLY:    state_d = ST_R;
        ST_R:       state_d = ST_SH_SU;
        ST_SH_SU:   state_d = ST_SH_LD;
        ST_SH_LD:   state_d = ST_SH_PRE;
        ST_SH_PRE:  state_d = ST_SH_RST;
        ST_SH_RST:  state_d = ST_SH_POST;
        ST_SH_POST: state_d = ST_WIN;
        default: begin
          state_d = run ? ST_RD_SU : ST_IDLE;
          adv     = run;
        end
      endcase
    end
  end

  always_comb begin
    if (state_d != state_q) cnt_d = ld_val(dur);
    else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
    else                    cnt_d = cnt_q;
  end

  assign s_start = (state_d == ST_S) && (state_q != ST_S);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/img_row_seq_cal.sv
module img_row_seq_cal
  import img_row_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] t_cal_dly,
  input  logic [CNT_W-1:0] t_cal_w,
  output logic             cal
);
  cal_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [CNT_W-1:0] ld_val(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (trig) begin
      ph_d  = CAL_WAIT;
      cnt_d = ld_val(t_cal_dly);
    end else if (ph_q != CAL_OFF) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_W'(1);
      end else if (ph_q == CAL_WAIT) begin
        ph_d  = CAL_ON;
        cnt_d = ld_val(t_cal_w);
      end else begin
        ph_d = CAL_OFF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= CAL_OFF;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign cal = (ph_q == CAL_ON);
endmodule

// File: rtl/img_row_seq.sv
module img_row_seq
  import img_row_seq_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int CNT_W   = 12,
  parameter int ADDR_SU = 2,
  parameter int LD_W    = 4,
  parameter int ADDR_HD = 2,
  localparam int INT_W  = ROW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ds_en,
  input  logic [ROW_W-1:0] win_start,
  input  logic [ROW_W-1:0] win_end,
  input  logic [ROW_W-1:0] row_step,
  input  logic [INT_W-1:0] int_rows,
  input  logic [CNT_W-1:0] t_settle,
  input  logic [CNT_W-1:0] t_pulse,
  input  logic [CNT_W-1:0] t_gap,
  input  logic [CNT_W-1:0] t_rst_w,
  input  logic [CNT_W-1:0] t_rdly,
  input  logic [CNT_W-1:0] t_pre,
  input  logic [CNT_W-1:0] t_post,
  input  logic [CNT_W-1:0] t_line,
  input  logic [CNT_W-1:0] t_cal_dly,
  input  logic [CNT_W-1:0] t_cal_w,
  output logic [ROW_W-1:0] row_addr_pins,
  output logic             row_load_n,
  output logic             s_pulse,
  output logic             r_pulse,
  output logic             row_rst,
  output logic             row_rst_ds,
  output logic             cal_pulse,
  output logic             readout_window
);
  logic             rst_meta, rst_sync_n;
  seq_state_e       state;
  logic             go, adv, s_start, first_line, sh_valid, shutter_half, sh_fire;
  logic [ROW_W-1:0] rd_row, sh_row, sel_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  img_row_seq_fsm #(.CNT_W(CNT_W), .ADDR_SU(ADDR_SU), .LD_W(LD_W), .ADDR_HD(ADDR_HD)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .run(run),
    .t_settle(t_settle), .t_pulse(t_pulse), .t_gap(t_gap), .t_rst_w(t_rst_w),
    .t_rdly(t_rdly), .t_pre(t_pre), .t_post(t_post), .t_line(t_line),
    .state_q(state), .go(go), .adv(adv), .s_start(s_start)
  );

  img_row_seq_addr #(.ROW_W(ROW_W), .INT_W(INT_W)) u_addr (
    .clk(clk), .rst_n(rst_sync_n), .go(go), .adv(adv),
    .win_start(win_start), .win_end(win_end), .row_step(row_step), .int_rows(int_rows),
    .rd_row(rd_row), .first_line(first_line), .sh_row(sh_row), .sh_valid(sh_valid)
  );

  img_row_seq_cal #(.CNT_W(CNT_W)) u_cal (
    .clk(clk), .rst_n(rst_sync_n), .trig(s_start && first_line),
    .t_cal_dly(t_cal_dly), .t_cal_w(t_cal_w), .cal(cal_pulse)
  );

  always_comb begin
    shutter_half = state inside {ST_SH_SU, ST_SH_LD, ST_SH_PRE, ST_SH_RST, ST_SH_POST, ST_WIN};
    sh_fire      = (state == ST_SH_RST) && sh_valid;
    if (state == ST_IDLE)  sel_row = '0;
    else if (shutter_half) sel_row = sh_row;
    else                   sel_row = rd_row;
  end

  for (genvar k = 0; k < ROW_W; k++) begin : g_rev
    assign row_addr_pins[k] = sel_row[ROW_W-1-k];
  end

  assign row_load_n     = !(state inside {ST_RD_LD, ST_SH_LD});
  assign s_pulse        = (state == ST_S);
  assign r_pulse        = (state == ST_R);
  assign row_rst        = (state == ST_RRST) || (sh_fire && !ds_en);
  assign row_rst_ds     = sh_fire && ds_en;
  assign readout_window = shutter_half;
endmodule

// File: rtl/img_row_seq_chk.sv
module img_row_seq_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ds_en,
  input logic [ROW_W-1:0] row_addr_pins,
  input logic             row_load_n,
  input logic             s_pulse,
  input logic             r_pulse,
  input logic             row_rst,
  input logic             row_rst_ds,
  input logic             readout_window
);
  AST_DS_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    row_rst_ds |-> ds_en); // R7
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s_pulse, r_pulse, row_rst, row_rst_ds, !row_load_n})); // R4
  AST_ADDR_STABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_load_n || $rose(row_load_n)) |-> $stable(row_addr_pins)); // R2
  AST_ADDR_HELD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (row_rst || row_rst_ds) |-> $stable(row_addr_pins)); // R5
  AST_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    readout_window |-> (!s_pulse && !r_pulse)); // R10
  AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_pulse) |-> readout_window); // R10
  AST_SAMPLE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_pulse) |-> (row_load_n && $past(row_load_n))); // R3
endmodule

bind img_row_seq img_row_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ds_en(ds_en), .row_addr_pins(row_addr_pins),
  .row_load_n(row_load_n), .s_pulse(s_pulse), .r_pulse(r_pulse), .row_rst(row_rst),
  .row_rst_ds(row_rst_ds), .readout_window(readout_window)
);

// File: tb/tb_img_row_seq.sv
`timescale 1ns/100ps
module tb_img_row_seq;
  localparam int SU = 2, LDW = 4, HD = 2;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, ds_en = 1'b0;
  logic [9:0]  win_start, win_end, row_step;
  logic [10:0] int_rows;
  logic [11:0] t_settle, t_pulse, t_gap, t_rst_w, t_rdly, t_pre, t_post, t_line, t_cal_dly, t_cal_w;
  logic [9:0]  row_addr_pins;
  logic        row_load_n, s_pulse, r_pulse, row_rst, row_rst_ds, cal_pulse, readout_window;

  typedef struct packed {
    logic [9:0] a;
    logic ld_n, s, r, rst, rds, cal, win;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  img_row_seq dut (.*);

  function automatic logic [9:0] rev(input int x);
    logic [9:0] v = 10'(x);
    logic [9:0] r;
    for (int k = 0; k < 10; k++) r[k] = v[9-k];
    return r;
  endfunction

  function automatic int m1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the queued reference, 1 ns after each edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      exp_t e;
      string ctx;
      if (q.size() > 0) begin
        e = q.pop_front();
        ctx = "";
      end else begin
        e = '{a: 10'd0, ld_n: 1'b1, default: 1'b0};
        ctx = rst_n ? " R11 idle" : " R12 reset";
      end
      chk({"R1 R6 R8 addr", ctx}, row_addr_pins, e.a);
      chk({"R2 R5 load_n", ctx}, row_load_n, e.ld_n);
      chk({"R3 s_pulse", ctx}, s_pulse, e.s);
      chk({"R4 r_pulse", ctx}, r_pulse, e.r);
      chk({"R4 R6 R7 row_rst", ctx}, row_rst, e.rst);
      chk({"R7 row_rst_ds", ctx}, row_rst_ds, e.rds);
      chk({"R9 cal", ctx}, cal_pulse, e.cal);
      chk({"R10 window", ctx}, readout_window, e.win);
    end
  end

  task automatic push(ref exp_t lq[$], input int n, input exp_t e);
    for (int i = 0; i < m1(n); i++) lq.push_back(e);
  endtask

  task automatic gen_line(input int rd, input bit first);
    exp_t lq[$];
    exp_t e;
    int sidx, sh, h;
    bit valid;
    e = '{a: rev(rd), ld_n: 1'b1, default: 1'b0};
    push(lq, SU, e);
    e.ld_n = 0; push(lq, LDW, e); e.ld_n = 1;
    push(lq, HD, e);
    push(lq, t_settle, e);
    sidx = lq.size();
    e.s = 1; push(lq, t_pulse, e); e.s = 0;
    push(lq, t_gap, e);
    e.rst = 1; push(lq, t_rst_w, e); e.rst = 0;
    push(lq, t_rdly, e);
    e.r = 1; push(lq, t_pulse, e); e.r = 0;
    sh = rd + int_rows;
    h  = win_end - win_start + 1;
    if (sh > win_end) sh = sh - h;
    valid = (sh <= win_end);
    e.a = rev(sh); e.win = 1;
    push(lq, SU, e);
    e.ld_n = 0; push(lq, LDW, e); e.ld_n = 1;
    push(lq, t_pre, e);
    if (valid) begin
      if (ds_en) e.rds = 1; else e.rst = 1;
    end
    push(lq, t_rst_w, e); e.rst = 0; e.rds = 0;
    push(lq, t_post, e);
    push(lq, t_line, e);
    if (first)
      for (int k = 0; k < m1(t_cal_w); k++) lq[sidx + m1(t_cal_dly) + k].cal = 1'b1;
    foreach (lq[i]) q.push_back(lq[i]);
  endtask

  task automatic scenario(input int nlines);
    int row = win_start;
    bit first = 1;
    for (int i = 0; i < nlines; i++) begin
      gen_line(row, first);
      if (row + row_step > win_end) begin
        row = win_start; first = 1;
      end else begin
        row = row + row_step; first = 0;
      end
    end
    run = 1'b1;
    while (q.size() > 3) @(negedge clk);
    run = 1'b0;
    while (q.size() > 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    win_start = 0; win_end = 0; row_step = 1; int_rows = 1;
    t_settle = 4; t_pulse = 3; t_gap = 1; t_rst_w = 2; t_rdly = 5;
    t_pre = 3; t_post = 2; t_line = 6; t_cal_dly = 2; t_cal_w = 4;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // A: unit step, frame wrap after 8 lines, shutter row wraps (R6 R8 R9)
    win_start = 2; win_end = 9; row_step = 1; int_rows = 3; ds_en = 0;
    scenario(10);
    // B: step 3, dual-slope shutter, some shutter rows suppressed (R6 R7)
    win_start = 5; win_end = 20; row_step = 3; int_rows = 20; ds_en = 1;
    t_settle = 6; t_pulse = 2; t_cal_dly = 1; t_cal_w = 2;
    scenario(8);
    // C: top of array, step overflows past 1023, zero counts act as one (R3 R8)
    win_start = 1000; win_end = 1023; row_step = 7; int_rows = 5; ds_en = 0;
    t_gap = 0; t_rdly = 0; t_post = 0; t_line = 4; t_cal_dly = 0; t_cal_w = 3;
    scenario(6);
    // D: integration longer than the window, every shutter pulse dropped (R6)
    int_rows = 1024;
    scenario(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired R11 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule